// File: doc/BRIEF.md
# Two-Wire Controller Command and Mode Register

This block is the write-only command register of a two-wire serial controller. Software writes a 32-bit word. Each bit that is written as 1 is one request. Bits written as 0 do nothing. Paired enable and disable requests keep six persistent mode flags: controller (master), target (slave), high-speed, SMBus, packet error checking and FIFO. Other requests become one-cycle command pulses that go to the bus engine: start, stop, quick command, bus clear, PEC request, holding-register flush and soft reset.

The block also works from status that the bus engine reports. A reported NACK, master-code acknowledge error or bus timeout sets a sticky lock. While the lock is set, no start is issued. The lock stays set until software writes the unlock request. A controller or target disable requested while that side is busy waits until the engine reports it idle. A stop requested during a controller read waits for the end of the current byte. A start that cannot be issued yet is held pending. A soft-reset request returns every flag, the lock and every pending request to the reset state.

Top module: `twc_cmd_reg`

## Requirements
- R1: After the synchronous reset, every mode flag is 0, the lock is 0 and every command pulse is 0.
- R2: A write with `wr_en` high has no effect through a bit written as 0. Bits 16 to 23 and 28 to 31 have no effect whatever their value.
- R3: The paired mode bits are: controller on/off at bits 2/3, target on/off at bits 4/5, high-speed on/off at bits 8/9, SMBus on/off at bits 10/11, PEC on/off at bits 12/13 and FIFO on/off at bits 26/27. An on bit sets its flag on the clock edge that takes the write. An off bit clears it on that edge. When both bits of a pair are 1, the flag ends up 0.
- R4: A controller-off request made while `mst_busy` is 1, or a target-off request made while `slv_busy` is 1, leaves the flag at 1. The flag clears on the first edge at which that busy input is 0.
- R5: A stop request (bit 1) gives one `stop_pulse` cycle right after the write. The exception is when `rd_mode` and `mst_busy` are both 1: the request then waits, and the pulse follows the edge at which `byte_done` is 1.
- R6: A quick-command request (bit 6) or a bus-clear request (bit 15) gives a one-cycle pulse only if the controller flag is 1 when the request is written. Otherwise the request is discarded.
- R7: A start request (bit 0) gives a one-cycle `start_pulse` once the controller flag is 1 and the lock is 0. Until then it stays pending. The pending request is discarded on the edge at which a controller-off request takes effect.
- R8: A 1 on `err_nack`, `err_mcode` or `err_tmo` sets the lock. An unlock request (bit 25) clears it. An error reported in the same cycle as an unlock request wins.
- R9: A PEC request (bit 14) and a holding-register flush request (bit 24) each give a one-cycle pulse right after the write.
- R10: A soft-reset request (bit 7) gives one `soft_reset_pulse` cycle. On the same edge it clears all mode flags, the lock and any pending start, stop or disable, so that a later `byte_done` issues no stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the command word |
| wr_data | input | 32 | Command word; a 1 in a bit is a request |
| mst_busy | input | 1 | Controller side still has a character in flight or data waiting to be sent |
| slv_busy | input | 1 | Target side still has a character in flight or data waiting to be sent |
| rd_mode | input | 1 | Current controller transfer is a read |
| byte_done | input | 1 | Current byte transfer finished this cycle |
| err_nack | input | 1 | NACK received |
| err_mcode | input | 1 | Master-code acknowledge error |
| err_tmo | input | 1 | Bus timeout |
| master_on | output | 1 | Controller mode flag |
| slave_on | output | 1 | Target mode flag |
| hs_on | output | 1 | High-speed mode flag |
| smb_on | output | 1 | SMBus mode flag |
| pec_on | output | 1 | Packet error checking flag |
| fifo_on | output | 1 | FIFO mode flag |
| locked | output | 1 | Error lock; blocks new starts |
| start_pulse | output | 1 | Issue a start |
| stop_pulse | output | 1 | Issue a stop |
| quick_pulse | output | 1 | Issue a quick command |
| bus_clear_pulse | output | 1 | Issue a bus clear |
| pec_req_pulse | output | 1 | Request PEC transmission or check |
| hold_flush_pulse | output | 1 | Empty the transmit holding register and set its ready and complete flags |
| soft_reset_pulse | output | 1 | Soft reset taken |

## Verification
The embedded assertions check these on every cycle:
- a disable wins over an enable whenever it is not deferred;
- a deferred flag stays set while its side is busy;
- every error input sets the lock;
- starts, quick commands and bus clears come only from a permitted state;
- a waiting stop gives no pulse before its byte ends;
- a soft reset clears the lock.

Some behaviours need a sequence of writes and status changes, so only the bench scenarios can show them. These are:
- a start that is held under the lock and issued one edge after unlock;
- a pending start discarded by a deferred controller disable;
- an error beating an unlock written in the same cycle;
- the ignored bit ranges;
- a waiting stop discarded by a soft reset.

// File: rtl/twc_pkg.sv
package twc_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned N_MODES = 6;

  // mode flag indices
  localparam int M_MST  = 0;
  localparam int M_SLV  = 1;
  localparam int M_HS   = 2;
  localparam int M_SMB  = 3;
  localparam int M_PEC  = 4;
  localparam int M_FIFO = 5;

  // command word bit positions (software-visible)
  localparam int B_GO       = 0;
  localparam int B_HALT     = 1;
  localparam int B_MST_ON   = 2;
  localparam int B_MST_OFF  = 3;
  localparam int B_SLV_ON   = 4;
  localparam int B_SLV_OFF  = 5;
  localparam int B_QUICK    = 6;
  localparam int B_SRST     = 7;
  localparam int B_HS_ON    = 8;
  localparam int B_HS_OFF   = 9;
  localparam int B_SMB_ON   = 10;
  localparam int B_SMB_OFF  = 11;
  localparam int B_PEC_ON   = 12;
  localparam int B_PEC_OFF  = 13;
  localparam int B_PEC_REQ  = 14;
  localparam int B_BUS_CLR  = 15;
  localparam int B_FLUSH    = 24;
  localparam int B_UNLOCK   = 25;
  localparam int B_FIFO_ON  = 26;
  localparam int B_FIFO_OFF = 27;

  typedef struct packed {
    logic [N_MODES-1:0] en;
    logic [N_MODES-1:0] dis;
    logic go;
    logic halt;
    logic quick;
    logic bus_clr;
    logic pec_req;
    logic flush;
    logic unlock;
    logic srst;
  } cmd_t;
endpackage

// File: rtl/twc_decode.sv
module twc_decode
  import twc_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output cmd_t         cmd
);
  logic unused_bits;
  assign unused_bits = ^{wr_data[23:16], wr_data[W-1:28]};

  always_comb begin
    cmd = '0;
    if (wr_en) begin
      cmd.en[M_MST]   = wr_data[B_MST_ON];
      cmd.dis[M_MST]  = wr_data[B_MST_OFF];
      cmd.en[M_SLV]   = wr_data[B_SLV_ON];
      cmd.dis[M_SLV]  = wr_data[B_SLV_OFF];
      cmd.en[M_HS]    = wr_data[B_HS_ON];
      cmd.dis[M_HS]   = wr_data[B_HS_OFF];
      cmd.en[M_SMB]   = wr_data[B_SMB_ON];
      cmd.dis[M_SMB]  = wr_data[B_SMB_OFF];
      cmd.en[M_PEC]   = wr_data[B_PEC_ON];
      cmd.dis[M_PEC]  = wr_data[B_PEC_OFF];
      cmd.en[M_FIFO]  = wr_data[B_FIFO_ON];
      cmd.dis[M_FIFO] = wr_data[B_FIFO_OFF];
      cmd.go          = wr_data[B_GO];
      cmd.halt        = wr_data[B_HALT];
      cmd.quick       = wr_data[B_QUICK];
      cmd.bus_clr     = wr_data[B_BUS_CLR];
      cmd.pec_req     = wr_data[B_PEC_REQ];
      cmd.flush       = wr_data[B_FLUSH];
      cmd.unlock      = wr_data[B_UNLOCK];
      cmd.srst        = wr_data[B_SRST];
    end
  end
endmodule

// File: rtl/twc_mode_flag.sv
module twc_mode_flag #(
  parameter bit DEFER = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic srst,
  input  logic en_req,
  input  logic dis_req,
  input  logic busy,
  output logic on_o,
  output logic off_evt
);
  logic pend_q;
  logic hold;

  assign hold = DEFER && busy;

  // flag clears on this edge
  always_comb begin
    off_evt = on_o && !srst &&
              (dis_req ? !hold : (!en_req && pend_q && !busy));
  end

  always_ff @(posedge clk) begin
    if (rst || srst) begin
      on_o   <= 1'b0;
      pend_q <= 1'b0;
    end else if (dis_req) begin
      if (hold) begin
        pend_q <= 1'b1;
      end else begin
        on_o   <= 1'b0;
        pend_q <= 1'b0;
      end
    end else if (en_req) begin
      on_o   <= 1'b1;
      pend_q <= 1'b0;
    end else if (pend_q && !busy) begin
      on_o   <= 1'b0;
      pend_q <= 1'b0;
    end
  end

  AST_DIS_WINS: assert property (@(posedge clk) disable iff (rst)
    (dis_req && !hold && !srst) |=> !on_o); // R3
  AST_DEFER_HOLD: assert property (@(posedge clk) disable iff (rst)
    (on_o && pend_q && busy && !srst) |=> on_o); // R4
endmodule

// File: rtl/twc_cmd_seq.sv
module twc_cmd_seq
  import twc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  cmd_t cmd,
  input  logic master_on,
  input  logic master_off_evt,
  input  logic rd_mode,
  input  logic mst_busy,
  input  logic byte_done,
  input  logic err_nack,
  input  logic err_mcode,
  input  logic err_tmo,
  output logic locked,
  output logic start_o,
  output logic stop_o,
  output logic quick_o,
  output logic clr_o,
  output logic pecrq_o,
  output logic flush_o,
  output logic srst_o
);
  logic start_pend;
  logic stop_pend;
  logic err_any;
  logic stop_wait;
  logic start_want;

  assign err_any    = err_nack || err_mcode || err_tmo;
  assign stop_wait  = rd_mode && mst_busy;
  assign start_want = cmd.go || start_pend;

  always_ff @(posedge clk) begin
    if (rst || cmd.srst) begin
      locked     <= 1'b0;
      start_pend <= 1'b0;
      stop_pend  <= 1'b0;
      start_o    <= 1'b0;
      stop_o     <= 1'b0;
      quick_o    <= 1'b0;
      clr_o      <= 1'b0;
      pecrq_o    <= 1'b0;
      flush_o    <= 1'b0;
      srst_o     <= !rst && cmd.srst;
    end else begin
      srst_o  <= 1'b0;
      quick_o <= cmd.quick && master_on;
      clr_o   <= cmd.bus_clr && master_on;
      pecrq_o <= cmd.pec_req;
      flush_o <= cmd.flush;

      if (err_any)         locked <= 1'b1;
      else if (cmd.unlock) locked <= 1'b0;

      if (master_off_evt) begin
        start_o    <= 1'b0;
        start_pend <= 1'b0;
      end else if (start_want && master_on && !locked) begin
        start_o    <= 1'b1;
        start_pend <= 1'b0;
      end else begin
        start_o    <= 1'b0;
        start_pend <= start_want;
      end

      stop_o <= (cmd.halt && !stop_wait) || (stop_pend && byte_done);
      if (cmd.halt) stop_pend <= stop_wait;
      else if (byte_done) stop_pend <= 1'b0;
    end
  end

  AST_LOCK_ON_ERR: assert property (@(posedge clk) disable iff (rst)
    (err_any && !cmd.srst) |=> locked); // R8
  AST_START_GATED: assert property (@(posedge clk) disable iff (rst)
    start_o |-> $past(master_on && !locked)); // R7
  AST_QUICK_GATED: assert property (@(posedge clk) disable iff (rst)
    (quick_o || clr_o) |-> $past(master_on)); // R6
  AST_STOP_WAITS: assert property (@(posedge clk) disable iff (rst)
    (stop_pend && !byte_done && !cmd.halt && !cmd.srst) |=> !stop_o); // R5
  AST_SRST_UNLOCK: assert property (@(posedge clk) disable iff (rst)
    cmd.srst |=> (!locked && !start_o && srst_o)); // R10
endmodule

// File: rtl/twc_cmd_reg.sv
module twc_cmd_reg
  import twc_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         mst_busy,
  input  logic         slv_busy,
  input  logic         rd_mode,
  input  logic         byte_done,
  input  logic         err_nack,
  input  logic         err_mcode,
  input  logic         err_tmo,
  output logic         master_on,
  output logic         slave_on,
  output logic         hs_on,
  output logic         smb_on,
  output logic         pec_on,
  output logic         fifo_on,
  output logic         locked,
  output logic         start_pulse,
  output logic         stop_pulse,
  output logic         quick_pulse,
  output logic         bus_clear_pulse,
  output logic         pec_req_pulse,
  output logic         hold_flush_pulse,
  output logic         soft_reset_pulse
);
  cmd_t               cmd;
  logic [N_MODES-1:0] mode_on;
  logic [N_MODES-1:0] off_evt;
  logic [N_MODES-1:0] busy_vec;

  twc_decode #(.W(W)) u_dec (
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .cmd     (cmd)
  );

  always_comb begin
    busy_vec        = '0;
    busy_vec[M_MST] = mst_busy;
    busy_vec[M_SLV] = slv_busy;
  end

  for (genvar i = 0; i < N_MODES; i++) begin : g_mode
    twc_mode_flag #(.DEFER((i == M_MST) || (i == M_SLV))) u_flag (
      .clk     (clk),
      .rst     (rst),
      .srst    (cmd.srst),
      .en_req  (cmd.en[i]),
      .dis_req (cmd.dis[i]),
      .busy    (busy_vec[i]),
      .on_o    (mode_on[i]),
      .off_evt (off_evt[i])
    );
  end

  twc_cmd_seq u_seq (
    .clk            (clk),
    .rst            (rst),
    .cmd            (cmd),
    .master_on      (mode_on[M_MST]),
    .master_off_evt (off_evt[M_MST]),
    .rd_mode        (rd_mode),
    .mst_busy       (mst_busy),
    .byte_done      (byte_done),
    .err_nack       (err_nack),
    .err_mcode      (err_mcode),
    .err_tmo        (err_tmo),
    .locked         (locked),
    .start_o        (start_pulse),
    .stop_o         (stop_pulse),
    .quick_o        (quick_pulse),
    .clr_o          (bus_clear_pulse),
    .pecrq_o        (pec_req_pulse),
    .flush_o        (hold_flush_pulse),
    .srst_o         (soft_reset_pulse)
  );

  assign master_on = mode_on[M_MST];
  assign slave_on  = mode_on[M_SLV];
  assign hs_on     = mode_on[M_HS];
  assign smb_on    = mode_on[M_SMB];
  assign pec_on    = mode_on[M_PEC];
  assign fifo_on   = mode_on[M_FIFO];

  AST_START_NOT_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (locked && !cmd.unlock && !cmd.srst) |=> !start_pulse); // R7
endmodule

// File: tb/twc_cmd_reg_test.sv
module twc_cmd_reg_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        mst_busy = 1'b0, slv_busy = 1'b0, rd_mode = 1'b0, byte_done = 1'b0;
  logic        err_nack = 1'b0, err_mcode = 1'b0, err_tmo = 1'b0;
  logic        master_on, slave_on, hs_on, smb_on, pec_on, fifo_on, locked;
  logic        start_pulse, stop_pulse, quick_pulse, bus_clear_pulse;
  logic        pec_req_pulse, hold_flush_pulse, soft_reset_pulse;

  always #(CLK_PERIOD/2) clk = ~clk;

  twc_cmd_reg uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .mst_busy(mst_busy), .slv_busy(slv_busy), .rd_mode(rd_mode), .byte_done(byte_done),
    .err_nack(err_nack), .err_mcode(err_mcode), .err_tmo(err_tmo),
    .master_on(master_on), .slave_on(slave_on), .hs_on(hs_on), .smb_on(smb_on),
    .pec_on(pec_on), .fifo_on(fifo_on), .locked(locked),
    .start_pulse(start_pulse), .stop_pulse(stop_pulse), .quick_pulse(quick_pulse),
    .bus_clear_pulse(bus_clear_pulse), .pec_req_pulse(pec_req_pulse),
    .hold_flush_pulse(hold_flush_pulse), .soft_reset_pulse(soft_reset_pulse)
  );

  typedef struct {
    logic [13:0] v;
    string       tag;
  } item_t;

  item_t q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;

  // expected state: e_mode = {master, slave, hs, smb, pec, fifo}
  logic [5:0] e_mode = '0;
  logic       e_lock = 1'b0;
  // next-cycle status inputs, applied by the driver
  logic       n_mb = 0, n_sb = 0, n_rd = 0, n_bd = 0;
  logic [2:0] n_err = '0; // {tmo, mcode, nack}

  localparam logic [6:0] P_START = 7'b1000000;
  localparam logic [6:0] P_STOP  = 7'b0100000;
  localparam logic [6:0] P_QUICK = 7'b0010000;
  localparam logic [6:0] P_CLR   = 7'b0001000;
  localparam logic [6:0] P_PECRQ = 7'b0000100;
  localparam logic [6:0] P_FLUSH = 7'b0000010;
  localparam logic [6:0] P_SRST  = 7'b0000001;

  function automatic logic [31:0] bt(input int n);
    return 32'd1 << n;
  endfunction

  task automatic step(input logic we, input logic [31:0] w, input logic [6:0] pl,
                      input string tag);
    item_t it;
    @(negedge clk);
    wr_en = we; wr_data = w;
    mst_busy = n_mb; slv_busy = n_sb; rd_mode = n_rd; byte_done = n_bd;
    {err_tmo, err_mcode, err_nack} = n_err;
    it.v = {e_mode, e_lock, pl};
    it.tag = tag;
    q.push_back(it);
  endtask

  // monitor: compares one expected item per clock edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      item_t it;
      logic [13:0] act;
      it = q.pop_front();
      act = {master_on, slave_on, hs_on, smb_on, pec_on, fifo_on, locked,
             start_pulse, stop_pulse, quick_pulse, bus_clear_pulse,
             pec_req_pulse, hold_flush_pulse, soft_reset_pulse};
      checks++;
      if (act !== it.v) begin
        errors++;
        $display("FAIL %s: actual %b expected %b", it.tag, act, it.v);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    step(0, 0, 0, "R1 reset state");
    step(1, 32'hF0FF_0000, 0, "R2 ignored bits");
    step(1, 0, 0, "R2 zero write");
    step(1, bt(6) | bt(15), 0, "R6 quick/clear dropped, controller off");
    e_mode[5] = 1; step(1, bt(2), 0, "R3 controller on");
    step(1, bt(0), P_START, "R7 start issued");
    step(1, bt(6) | bt(15), P_QUICK | P_CLR, "R6 quick/clear issued");
    n_err = 3'b001; e_lock = 1; step(0, 0, 0, "R8 nack locks"); n_err = 0;
    step(1, bt(0), 0, "R7 start held under lock");
    step(0, 0, 0, "R7 start still held");
    n_err = 3'b100; step(1, bt(25), 0, "R8 error beats unlock"); n_err = 0;
    e_lock = 0; step(1, bt(25), 0, "R8 unlock");
    step(0, 0, P_START, "R7 pending start issued after unlock");
    e_mode[5] = 0; step(1, bt(2) | bt(3), 0, "R3 off wins over on");
    e_mode[4:0] = 5'b11111;
    step(1, bt(4) | bt(8) | bt(10) | bt(12) | bt(26), 0, "R3 enable five modes");
    e_mode[2] = 0; step(1, bt(10) | bt(11), 0, "R3 smbus both bits");
    e_mode[3] = 0; e_mode[1] = 0; e_mode[0] = 0;
    step(1, bt(9) | bt(13) | bt(27), 0, "R3 hs pec fifo off");
    n_sb = 1; step(1, bt(5), 0, "R4 target off deferred");
    step(0, 0, 0, "R4 target held while busy");
    n_sb = 0; e_mode[4] = 0; step(0, 0, 0, "R4 target off when idle");
    e_mode[5] = 1; step(1, bt(2), 0, "R3 controller on again");
    n_err = 3'b010; e_lock = 1; step(0, 0, 0, "R8 master-code error locks"); n_err = 0;
    step(1, bt(0), 0, "R7 start pending under lock");
    n_mb = 1; step(1, bt(3), 0, "R4 controller off deferred");
    step(0, 0, 0, "R4 controller held while busy");
    n_mb = 0; e_mode[5] = 0; step(0, 0, 0, "R4 controller off when idle");
    e_lock = 0; step(1, bt(25), 0, "R8 unlock again");
    e_mode[5] = 1; step(1, bt(2), 0, "R3 controller on third time");
    step(0, 0, 0, "R7 discarded start not issued");
    n_mb = 1; n_rd = 1; step(1, bt(1), 0, "R5 stop waits during read");
    step(0, 0, 0, "R5 stop still waiting");
    n_bd = 1; step(0, 0, P_STOP, "R5 stop after byte done"); n_bd = 0;
    step(0, 0, 0, "R5 single stop only");
    n_rd = 0; step(1, bt(1), P_STOP, "R5 stop immediate outside read");
    step(1, bt(14) | bt(24), P_PECRQ | P_FLUSH, "R9 pec request and flush");
    step(0, 0, 0, "R9 pulses last one cycle");
    n_rd = 1; step(1, bt(1), 0, "R5 stop pending before soft reset");
    n_err = 3'b001; e_lock = 1; step(0, 0, 0, "R8 lock before soft reset"); n_err = 0;
    e_mode[3] = 1; step(1, bt(8), 0, "R3 hs on");
    e_mode = '0; e_lock = 0; step(1, bt(7), P_SRST, "R10 soft reset");
    n_bd = 1; step(0, 0, 0, "R10 waiting stop discarded"); n_bd = 0;
    n_mb = 0; n_rd = 0; step(1, bt(6), 0, "R10 controller off after soft reset");
    step(0, 0, 0, "R10 idle after soft reset");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule